// File: doc/BRIEF.md
# Channel Gate and Protection Logic

This block makes the gate-enable decision for a bank of low-side output channels. Each channel has a request bit from the serial control registers. A per-channel map enable decides whether one shared, already synchronised input pin takes part. When it does, a per-channel operator bit picks OR or AND to combine the pin with the request. The combined request then passes through a per-channel protection state machine. That machine handles current-limit and over-temperature indications from the analog side, which reach this block as digital inputs.

Each channel picks its overload response: stay on in current limit and raise a flag after a fault delay, or switch off after a shutdown delay. It also picks its thermal response: restart automatically once the over-temperature indication clears, or stay off until cleared. A low-to-high transition of the input pin clears a channel's latched flags and releases its latched shutdowns. Both delays are counted in system clock cycles. The slew-select output copies the slew configuration bit of each channel unchanged.

Each channel runs a state machine with four states: `CH_NORMAL` (gate follows the request), `CH_OVLD` (request on, current limit active, delay counting), `CH_OLOFF` (overload shutdown, gate off) and `CH_HOT` (over-temperature, gate off). These are its transitions:
- NORMAL to OVLD: request and current limit are both high.
- OVLD to NORMAL: the request or the current limit drops, and the counter clears.
- OVLD to OLOFF: the shutdown delay expires with the channel in shutdown overload mode.
- OLOFF to NORMAL: the input pin rises.
- any state to HOT: over-temperature is high.
- HOT to NORMAL: over-temperature is low, and either the channel is in restart mode or the input pin rises.

Top module: `chan_gate_top`

## Requirements
- R1: With its map bit 0, a fault-free channel's gate enable equals its output-control bit, whatever the input pin does.
- R2: With its map bit 1 and its operator bit 0, a fault-free channel's gate enable is the OR of its output-control bit and the input pin.
- R3: With its map bit 1 and its operator bit 1, a fault-free channel's gate enable is the AND of its output-control bit and the input pin.
- R4: An over-temperature indication forces the channel's gate enable low in the same cycle. Its over-temperature flag reads 1 after the next clock edge.
- R5: In thermal mode 0, the gate enable stays low for the cycle in which the indication first reads low. It follows the request again after the next clock edge.
- R6: In thermal mode 1, the gate enable stays low after the indication clears until the input pin rises. After that rising edge is clocked, the gate follows the request again and the flag reads 0.
- R7: In overload mode 0, the gate stays on during current limit. The overload flag reads 1 after FAULT_DLY consecutive clock edges with both current limit and request high, and not before.
- R8: In overload mode 1, after SHUT_DLY consecutive such edges the gate goes low and the overload flag reads 1. The gate stays low after the limit indication drops, until the input pin rises.
- R9: A drop of the current-limit indication restarts the delay count, so interrupted overload shorter than the delay never sets the flag.
- R10: A clocked rising edge of the input pin clears the overload and over-temperature flags of every channel whose fault indication is low.
- R11: The slew-select output equals the slew configuration input bit for bit.
- R12: After reset all flags read 0 and all state machines are in `CH_NORMAL`, so with all-zero requests every gate enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pin | input | 1 | Synchronised shared input pin |
| cfg_out | input | N_CH | Output-control bit per channel |
| cfg_map | input | N_CH | Map enable per channel (1 = pin participates) |
| cfg_bool | input | N_CH | Operator per channel (0 = OR, 1 = AND) |
| cfg_slew | input | N_CH | Slew configuration per channel |
| cfg_ovl_mode | input | N_CH | Overload mode (0 = limit and flag, 1 = shut down) |
| cfg_ot_mode | input | N_CH | Thermal mode (0 = auto restart, 1 = latched) |
| ilim_act | input | N_CH | Current limit active per channel |
| ot_act | input | N_CH | Over-temperature indication per channel |
| gate_en | output | N_CH | Gate enable per channel |
| slew_sel | output | N_CH | Slew select per channel |
| ol_flag | output | N_CH | Latched overload event per channel |
| ot_flag | output | N_CH | Latched over-temperature event per channel |

## Verification
The bench builds the block with eight channels, FAULT_DLY of 4 and SHUT_DLY of 6. These short delays put the exact trip edge of both overload modes within a few cycles, so the bench can probe one edge before the trip and the trip edge itself. The two delays differ, so a wrong choice of delay for a mode changes the trip cycle. With a short delay, an interrupted overload of three cycles sits just below the threshold and shows whether the counter restarts.

// File: rtl/chan_gate_pkg.sv
package chan_gate_pkg;
    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_OVLD   = 2'd1,
        CH_OLOFF  = 2'd2,
        CH_HOT    = 2'd3
    } ch_state_e;
endpackage

// File: rtl/chan_edge_det.sv
module chan_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/chan_req_mix.sv
module chan_req_mix #(
    parameter int N_CH = 8
) (
    input  logic            in_pin,
    input  logic [N_CH-1:0] cfg_out,
    input  logic [N_CH-1:0] cfg_map,
    input  logic [N_CH-1:0] cfg_bool,
    output logic [N_CH-1:0] req
);
    for (genvar i = 0; i < N_CH; i++) begin : g_mix
        logic comb;
        assign comb   = cfg_bool[i] ? (cfg_out[i] & in_pin) : (cfg_out[i] | in_pin);
        assign req[i] = cfg_map[i] ? comb : cfg_out[i];
    end
endmodule

// File: rtl/chan_prot_fsm.sv
module chan_prot_fsm
    import chan_gate_pkg::*;
#(
    parameter int FAULT_DLY = 10000,
    parameter int SHUT_DLY  = 3000,
    parameter int CW        = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ilim,
    input  logic ot,
    input  logic rise,
    input  logic ovl_mode,
    input  logic ot_mode,
    output logic gate,
    output logic ol_flag,
    output logic ot_flag
);
    localparam logic [CW-1:0] F_LAST = CW'(FAULT_DLY - 1);
    localparam logic [CW-1:0] S_LAST = CW'(SHUT_DLY - 1);

    ch_state_e     st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          trip;
    logic [CW-1:0] last;

    assign last = ovl_mode ? S_LAST : F_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CH_NORMAL;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        trip  = 1'b0;
        if (ot) begin
            st_n  = CH_HOT;
            cnt_n = '0;
        end else begin
            unique case (st)
                CH_NORMAL: begin
                    if (req && ilim) begin
                        st_n  = CH_OVLD;
                        cnt_n = CW'(1);
                    end
                end
                CH_OVLD: begin
                    if (!req || !ilim) begin
                        st_n  = CH_NORMAL;
                        cnt_n = '0;
                    end else if (cnt >= last) begin
                        trip = 1'b1;
                        if (ovl_mode) begin
                            st_n  = CH_OLOFF;
                            cnt_n = '0;
                        end
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
                CH_OLOFF: begin
                    if (rise) st_n = CH_NORMAL;
                end
                CH_HOT: begin
                    if (!ot_mode || rise) st_n = CH_NORMAL;
                end
                default: st_n = CH_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ol_flag <= 1'b0;
            ot_flag <= 1'b0;
        end else begin
            if (trip)      ol_flag <= 1'b1;
            else if (rise) ol_flag <= 1'b0;
            if (ot)        ot_flag <= 1'b1;
            else if (rise) ot_flag <= 1'b0;
        end
    end

    always_comb begin
        gate = 1'b0;
        unique case (st)
            CH_NORMAL, CH_OVLD: gate = req & ~ot;
            CH_OLOFF, CH_HOT:   gate = 1'b0;
            default:            gate = 1'b0;
        endcase
    end
endmodule

// File: rtl/chan_gate_top.sv
module chan_gate_top #(
    parameter int N_CH      = 8,
    parameter int FAULT_DLY = 10000,
    parameter int SHUT_DLY  = 3000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_pin,
    input  logic [N_CH-1:0] cfg_out,
    input  logic [N_CH-1:0] cfg_map,
    input  logic [N_CH-1:0] cfg_bool,
    input  logic [N_CH-1:0] cfg_slew,
    input  logic [N_CH-1:0] cfg_ovl_mode,
    input  logic [N_CH-1:0] cfg_ot_mode,
    input  logic [N_CH-1:0] ilim_act,
    input  logic [N_CH-1:0] ot_act,
    output logic [N_CH-1:0] gate_en,
    output logic [N_CH-1:0] slew_sel,
    output logic [N_CH-1:0] ol_flag,
    output logic [N_CH-1:0] ot_flag
);
    localparam int DMAX = (FAULT_DLY > SHUT_DLY) ? FAULT_DLY : SHUT_DLY;
    localparam int CW   = $clog2(DMAX + 1);

    logic            pin_rise;
    logic [N_CH-1:0] req;

    chan_edge_det edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (in_pin),
        .rise (pin_rise)
    );

    chan_req_mix #(.N_CH(N_CH)) mix_i (
        .in_pin  (in_pin),
        .cfg_out (cfg_out),
        .cfg_map (cfg_map),
        .cfg_bool(cfg_bool),
        .req     (req)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        chan_prot_fsm #(
            .FAULT_DLY(FAULT_DLY),
            .SHUT_DLY (SHUT_DLY),
            .CW       (CW)
        ) fsm_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req[i]),
            .ilim    (ilim_act[i]),
            .ot      (ot_act[i]),
            .rise    (pin_rise),
            .ovl_mode(cfg_ovl_mode[i]),
            .ot_mode (cfg_ot_mode[i]),
            .gate    (gate_en[i]),
            .ol_flag (ol_flag[i]),
            .ot_flag (ot_flag[i])
        );
    end

    assign slew_sel = cfg_slew;
endmodule

// File: rtl/chan_gate_chk.sv
module chan_gate_chk #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_pin,
    input logic [N_CH-1:0] cfg_out,
    input logic [N_CH-1:0] cfg_map,
    input logic [N_CH-1:0] cfg_ovl_mode,
    input logic [N_CH-1:0] ilim_act,
    input logic [N_CH-1:0] ot_act,
    input logic [N_CH-1:0] gate_en,
    input logic [N_CH-1:0] ol_flag,
    input logic [N_CH-1:0] ot_flag
);
    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        p_unmapped_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_map[i] && !cfg_out[i]) |-> !gate_en[i]);

        p_hot_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ot_act[i] |-> !gate_en[i]);

        p_hot_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ot_act[i] |=> ot_flag[i]);

        p_cool_cycle_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ot_act[i]) |-> !gate_en[i]);

        p_shutdown_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ol_flag[i]) && cfg_ovl_mode[i] && $past(cfg_ovl_mode[i])) |-> !gate_en[i]);

        p_ot_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(in_pin) && !ot_act[i]) |=> !ot_flag[i]);

        p_ol_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(in_pin) && !ilim_act[i]) |=> !ol_flag[i]);
    end
endmodule

bind chan_gate_top chan_gate_chk #(.N_CH(N_CH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_pin      (in_pin),
    .cfg_out     (cfg_out),
    .cfg_map     (cfg_map),
    .cfg_ovl_mode(cfg_ovl_mode),
    .ilim_act    (ilim_act),
    .ot_act      (ot_act),
    .gate_en     (gate_en),
    .ol_flag     (ol_flag),
    .ot_flag     (ot_flag)
);

// File: tb/chan_gate_top_tb_top.sv
module chan_gate_top_tb_top;
    localparam int N  = 8;
    localparam int FD = 4;
    localparam int SD = 6;

    // {map, bool, out, pin, expected gate}
    localparam logic [4:0] VEC_TAB [8] = '{
        5'b0_0_0_1_0, 5'b0_0_1_0_1, 5'b1_0_0_1_1, 5'b1_0_0_0_0,
        5'b1_1_1_0_0, 5'b1_1_1_1_1, 5'b1_1_0_1_0, 5'b1_0_1_0_1
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_pin;
    logic [N-1:0] cfg_out, cfg_map, cfg_bool, cfg_slew, cfg_ovl_mode, cfg_ot_mode;
    logic [N-1:0] ilim_act, ot_act;
    logic [N-1:0] gate_en, slew_sel, ol_flag, ot_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    chan_gate_top #(.N_CH(N), .FAULT_DLY(FD), .SHUT_DLY(SD)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_pin(in_pin),
        .cfg_out(cfg_out), .cfg_map(cfg_map), .cfg_bool(cfg_bool),
        .cfg_slew(cfg_slew), .cfg_ovl_mode(cfg_ovl_mode), .cfg_ot_mode(cfg_ot_mode),
        .ilim_act(ilim_act), .ot_act(ot_act),
        .gate_en(gate_en), .slew_sel(slew_sel), .ol_flag(ol_flag), .ot_flag(ot_flag)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic look();
        #4;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_pin = 1'b0;
        cfg_out = '0; cfg_map = '0; cfg_bool = '0; cfg_slew = '0;
        cfg_ovl_mode = '0; cfg_ot_mode = '0; ilim_act = '0; ot_act = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick(); look();
        chk("R12 gate after reset", gate_en, 8'h00);
        chk("R12 ol_flag after reset", ol_flag, 8'h00);
        chk("R12 ot_flag after reset", ot_flag, 8'h00);

        cfg_slew = 8'hA5;
        #1 chk("R11 slew mirror", slew_sel, 8'hA5);

        for (int k = 0; k < 8; k++) begin
            logic m, b, o, p, e;
            {m, b, o, p, e} = VEC_TAB[k];
            tick();
            cfg_map = {N{m}}; cfg_bool = {N{b}}; cfg_out = {N{o}}; in_pin = p;
            look();
            chk(m ? (b ? "R3 AND vector" : "R2 OR vector") : "R1 unmapped vector", gate_en, {N{e}});
        end

        tick();
        cfg_map = 8'h08; cfg_bool = 8'h00; cfg_out = 8'h01; in_pin = 1'b1;
        look();
        chk("R2 only ch3 mapped, OR", gate_en, 8'h09);
        cfg_bool = 8'h08;
        #1 chk("R3 only ch3 mapped, AND with out=0", gate_en, 8'h01);

        // protection tests on channel 2, all channels unmapped
        tick();
        cfg_map = '0; cfg_bool = '0; in_pin = 1'b0; cfg_out = 8'h04;
        tick(); look();
        chk("R1 ch2 on", gate_en, 8'h04);

        // thermal mode 0
        tick(); ot_act = 8'h04; look();
        chk("R4 hot forces off same cycle", gate_en, 8'h00);
        tick(); ot_act = 8'h00; look();
        chk("R4 hot flag set", ot_flag, 8'h04);
        chk("R5 still off in cooling cycle", gate_en, 8'h00);
        tick(); look();
        chk("R5 auto restart", gate_en, 8'h04);
        chk("R5 flag held after restart", ot_flag, 8'h04);
        in_pin = 1'b1;
        tick(); look();
        chk("R10 ot flag cleared by pin rise", ot_flag, 8'h00);
        in_pin = 1'b0;

        // thermal mode 1
        cfg_ot_mode = 8'h04;
        tick(); ot_act = 8'h04;
        tick(); ot_act = 8'h00;
        tick(); tick(); tick(); look();
        chk("R6 latched off after cooling", gate_en, 8'h00);
        chk("R6 latched flag", ot_flag, 8'h04);
        in_pin = 1'b1;
        tick(); look();
        chk("R6 released by pin rise", gate_en, 8'h04);
        chk("R6 flag cleared", ot_flag, 8'h00);
        in_pin = 1'b0;
        cfg_ot_mode = 8'h00;

        // overload mode 0
        tick(); ilim_act = 8'h04;
        for (int e = 1; e < FD; e++) begin
            tick(); look();
            chk("R7 no flag before fault delay", ol_flag, 8'h00);
        end
        tick(); look();
        chk("R7 flag at fault delay", ol_flag, 8'h04);
        chk("R7 gate stays on in limit", gate_en, 8'h04);
        ilim_act = 8'h00;
        tick(); in_pin = 1'b1;
        tick(); look();
        chk("R10 ol flag cleared by pin rise", ol_flag, 8'h00);
        in_pin = 1'b0;

        // interrupted overload
        tick(); ilim_act = 8'h04;
        repeat (FD - 1) tick();
        ilim_act = 8'h00;
        tick(); ilim_act = 8'h04;
        repeat (FD - 1) tick();
        look();
        chk("R9 interrupted overload sets no flag", ol_flag, 8'h00);
        ilim_act = 8'h00;
        tick();

        // overload mode 1
        cfg_ovl_mode = 8'h04;
        tick(); ilim_act = 8'h04;
        for (int e = 1; e < SD; e++) begin
            tick(); look();
            chk("R8 on before shutdown delay", gate_en, 8'h04);
        end
        tick(); look();
        chk("R8 off at shutdown delay", gate_en, 8'h00);
        chk("R8 flag at shutdown", ol_flag, 8'h04);
        ilim_act = 8'h00;
        tick(); tick(); look();
        chk("R8 stays off after limit drops", gate_en, 8'h00);
        in_pin = 1'b1;
        tick(); look();
        chk("R8 restored by pin rise", gate_en, 8'h04);
        chk("R10 ol flag cleared after shutdown", ol_flag, 8'h00);
        in_pin = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule